// File: doc/BRIEF.md
# Three-Plane Overlay Alpha Compositor

This block lays up to three bitmap overlay planes over a live external video stream, one pixel per clock. A video beat arrives together with one pixel from each plane. A plane pixel is either a direct 16-bit colour or an 8-bit index into an internal 256-entry colour table that the CPU writes. Each plane pixel has its own 4-bit blend level. A runtime-programmable stacking order places the three planes and the video layer in four slots, from the bottom slot to the top slot. The block blends every layer onto the result of the layers below it and emits a 24-bit RGB pixel. Alongside that pixel it emits an active-low superimpose flag, so that an external mixer can also switch between the video and the overlay.

The video side and the result side are valid/ready streams. A video beat transfers on a rising edge where `vid_valid` and `vid_ready` are both high. The plane inputs and `vid_fmt` are sampled on that same edge. A result transfers on an edge where `out_valid` and `out_ready` are both high. While a result waits, it is held unchanged and back-pressure stops new input. The colour table and the order register are written through plain control strobes, and the bench changes them only while no pixel is in flight.

Top module: `overlay_mixer`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sup_n` is 1 and `vid_ready` is 1. The default stacking order is video in slot 0, plane 0 in slot 1, plane 1 in slot 2 and plane 2 in slot 3 (order word 8'h93).
- R2: `vid_ready` equals `!out_valid || out_ready`. A beat accepted on edge n is presented on the outputs from edge n+1 when there is no back-pressure. While `out_valid && !out_ready`, the outputs `out_rgb` and `out_sup_n` stay stable and no beat is accepted.
- R3: When a plane is in direct mode (`pl_palmode` bit 0), its pixel is RGB565: R in [15:11], G in [10:5], B in [4:0]. Each channel is widened to 8 bits by repeating its top bits below it.
- R4: When a plane is in table mode (`pl_palmode` bit 1), bits [7:0] of its pixel index the colour table. A table entry is {R[23:16], G[15:8], B[7:0]} and is written with `pal_we`, `pal_waddr` and `pal_wdata`.
- R5: Each layer is blended per channel as floor((a*fg + (15-a)*bg)/15), with 8-bit channels. The layer below slot 0 is black. Alpha 0 leaves the lower result unchanged and alpha 15 replaces it.
- R6: A plane whose `pl_en` bit or `pl_valid` bit is 0 is treated as alpha 0.
- R7: The order word holds one 2-bit layer ID per slot, with slot k in bits [2k+1:2k]. IDs 0 to 2 are planes and ID 3 is video. A write through `ord_we` takes effect only if the word is a permutation of the IDs 0 to 3. Any other word leaves the order unchanged.
- R8: The video layer is fully opaque. Any plane in a slot below the video slot has no effect on the output.
- R9: When `vid_fmt` is 0, video is RGB666 with R in `vid_data`[17:12], G in [11:6] and B in [5:0]. Each channel is widened to 8 bits by bit repetition.
- R10: When `vid_fmt` is 1, `vid_data`[15:8] is Y and [7:0] is chroma. Chroma alternates Cb and Cr on the accepted 4:2:2 beats, starting with Cb after reset. Each pixel uses its own chroma byte and the most recent byte of the other kind, which is 128 after reset. With dcb=Cb-128 and dcr=Cr-128, the conversion is R=Y+((359*dcr)>>>8), G=Y-((88*dcb+183*dcr)>>>8), B=Y+((454*dcb)>>>8), each clamped to 0..255.
- R11: `out_sup_n` is 0 exactly when some plane in a slot above the video slot has a nonzero effective alpha.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_valid | input | 1 | Video beat valid |
| vid_ready | output | 1 | Block can take a beat |
| vid_fmt | input | 1 | 0: RGB666, 1: YCrCb 4:2:2 |
| vid_data | input | 18 | Video pixel |
| pl_en | input | 3 | Per-plane enable |
| pl_palmode | input | 3 | Per-plane table mode |
| pl_valid | input | 3 | Per-plane pixel present |
| pl_pix | input | 48 | Plane pixels, plane p in [16p+15:16p] |
| pl_alpha | input | 12 | Plane alphas, plane p in [4p+3:4p] |
| pal_we | input | 1 | Colour table write strobe |
| pal_waddr | input | 8 | Colour table write index |
| pal_wdata | input | 24 | Colour table entry |
| ord_we | input | 1 | Order register write strobe |
| ord_wdata | input | 8 | Proposed order word |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_rgb | output | 24 | Result {R,G,B} |
| out_sup_n | output | 1 | Active-low superimpose flag |

## Verification
A wrong order register shows up on the first pixel where two layers with differing colours change places. The same pixel also shows the wrong `out_sup_n` when a plane crosses the video slot. A wrong chroma phase or a wrong chroma hold register shifts the colour of the first YCrCb pixel after the fault, on the very next result. A stage that fails to stall shows as a changed or dropped result during the first back-pressured cycle. Every result is compared with a behavioural model on the cycle it is consumed, so a fault is reported at most one result after it arises.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CH_W  = 8;
  localparam int RGB_W = 3 * CH_W;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic rgb_t from565(input logic [15:0] p);
    rgb_t c;
    c.r = widen5(p[15:11]);
    c.g = widen6(p[10:5]);
    c.b = widen5(p[4:0]);
    return c;
  endfunction
endpackage

// File: rtl/ovl_palette.sv
module ovl_palette #(
  parameter int DEPTH = 256,
  parameter int NRD   = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DW    = ovl_pkg::RGB_W
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IDX_W-1:0]     waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [NRD*IDX_W-1:0] rd_idx,
  output logic [NRD*DW-1:0]    rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    assign rd_data[i*DW +: DW] = mem[rd_idx[i*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/ovl_order_reg.sv
module ovl_order_reg #(
  parameter int NSLOT = 4,
  localparam int ID_W  = $clog2(NSLOT),
  localparam int ORD_W = NSLOT * ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ORD_W-1:0] wdata,
  output logic [ORD_W-1:0] order
);
  function automatic logic is_perm(input logic [ORD_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int id = 0; id < NSLOT; id++) begin
      int n;
      n = 0;
      for (int s = 0; s < NSLOT; s++)
        if (v[s*ID_W +: ID_W] == ID_W'(id)) n++;
      if (n != 1) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [ORD_W-1:0] reset_order();
    logic [ORD_W-1:0] v;
    v[0 +: ID_W] = ID_W'(NSLOT - 1);
    for (int s = 1; s < NSLOT; s++) v[s*ID_W +: ID_W] = ID_W'(s - 1);
    return v;
  endfunction

  localparam logic [ORD_W-1:0] RST_ORD = reset_order();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  order <= RST_ORD;
    else if (we && is_perm(wdata)) order <= wdata;
  end

  p_bad_order_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !is_perm(wdata)) |=> $stable(order));
  p_good_order_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_perm(wdata)) |=> (order == $past(wdata)));
endmodule

// File: rtl/ovl_vid_front.sv
module ovl_vid_front import ovl_pkg::*; #(
  parameter int VID_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             fmt,
  input  logic [VID_W-1:0] data,
  output rgb_t             pix
);
  logic       phase;
  logic [7:0] cb_h, cr_h, cb_c, cr_c;
  int yv, dcb, dcr, rr, gg, bb;

  function automatic logic [CH_W-1:0] clip(input int v);
    if (v < 0)   return '0;
    if (v > 255) return '1;
    return v[CH_W-1:0];
  endfunction

  always_comb begin
    cb_c = phase ? cb_h : data[7:0];
    cr_c = phase ? data[7:0] : cr_h;
    yv   = int'(data[15:8]);
    dcb  = int'(cb_c) - 128;
    dcr  = int'(cr_c) - 128;
    rr   = yv + ((359 * dcr) >>> 8);
    gg   = yv - ((88 * dcb + 183 * dcr) >>> 8);
    bb   = yv + ((454 * dcb) >>> 8);
    if (fmt) begin
      pix.r = clip(rr);
      pix.g = clip(gg);
      pix.b = clip(bb);
    end else begin
      pix.r = widen6(data[17:12]);
      pix.g = widen6(data[11:6]);
      pix.b = widen6(data[5:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      cb_h  <= 8'd128;
      cr_h  <= 8'd128;
    end else if (take && fmt) begin
      phase <= ~phase;
      if (!phase) cb_h <= data[7:0];
      else        cr_h <= data[7:0];
    end
  end

  p_phase_flips_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fmt) |=> (phase != $past(phase)));
  p_phase_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && fmt) |=> $stable(phase));
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend import ovl_pkg::*; #(
  parameter int AW = 4
) (
  input  rgb_t          fg,
  input  rgb_t          bg,
  input  logic [AW-1:0] alpha,
  output rgb_t          mix
);
  localparam int AMAX = (1 << AW) - 1;
  localparam int SW   = CH_W + AW;

  logic [2:0][CH_W-1:0] f_c, b_c, y_c;
  logic [AW-1:0]        inv_a;

  assign f_c   = fg;
  assign b_c   = bg;
  assign inv_a = AW'(AMAX) - alpha;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [SW-1:0] prod_f, prod_b, sum, quo;
    assign prod_f = SW'(f_c[c]) * SW'(alpha);
    assign prod_b = SW'(b_c[c]) * SW'(inv_a);
    assign sum    = prod_f + prod_b;
    assign quo    = sum / SW'(AMAX);
    assign y_c[c] = quo[CH_W-1:0];
  end

  assign mix = y_c;
endmodule

// File: rtl/overlay_mixer.sv
module overlay_mixer import ovl_pkg::*; #(
  parameter int NPLANE    = 3,
  parameter int AW        = 4,
  parameter int PIX_W     = 16,
  parameter int VID_W     = 18,
  parameter int PAL_DEPTH = 256,
  localparam int NSLOT    = NPLANE + 1,
  localparam int ID_W     = $clog2(NSLOT),
  localparam int ORD_W    = NSLOT * ID_W,
  localparam int IDX_W    = $clog2(PAL_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vid_valid,
  output logic                  vid_ready,
  input  logic                  vid_fmt,
  input  logic [VID_W-1:0]      vid_data,
  input  logic [NPLANE-1:0]     pl_en,
  input  logic [NPLANE-1:0]     pl_palmode,
  input  logic [NPLANE-1:0]     pl_valid,
  input  logic [NPLANE*PIX_W-1:0] pl_pix,
  input  logic [NPLANE*AW-1:0]  pl_alpha,
  input  logic                  pal_we,
  input  logic [IDX_W-1:0]      pal_waddr,
  input  logic [RGB_W-1:0]      pal_wdata,
  input  logic                  ord_we,
  input  logic [ORD_W-1:0]      ord_wdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [RGB_W-1:0]      out_rgb,
  output logic                  out_sup_n
);
  localparam logic [ID_W-1:0] VID_ID = ID_W'(NPLANE);

  logic               adv, take;
  logic [ORD_W-1:0]   order;
  rgb_t               vid_pix;
  logic [NPLANE*IDX_W-1:0] pal_idx;
  logic [NPLANE*RGB_W-1:0] pal_rd;

  assign adv       = !out_valid || out_ready;
  assign vid_ready = adv;
  assign take      = vid_valid && adv;

  ovl_order_reg #(.NSLOT(NSLOT)) u_order (
    .clk(clk), .rst_n(rst_n), .we(ord_we), .wdata(ord_wdata), .order(order)
  );

  ovl_vid_front #(.VID_W(VID_W)) u_front (
    .clk(clk), .rst_n(rst_n), .take(take), .fmt(vid_fmt), .data(vid_data), .pix(vid_pix)
  );

  for (genvar p = 0; p < NPLANE; p++) begin : g_idx
    assign pal_idx[p*IDX_W +: IDX_W] = pl_pix[p*PIX_W +: IDX_W];
  end

  ovl_palette #(.DEPTH(PAL_DEPTH), .NRD(NPLANE)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_waddr), .wdata(pal_wdata),
    .rd_idx(pal_idx), .rd_data(pal_rd)
  );

  // Stage 1: per-plane colour and effective alpha, plus video colour
  logic          s1_vld;
  rgb_t          s1_vid;
  rgb_t          s1_fg [NPLANE];
  logic [AW-1:0] s1_a  [NPLANE];

  for (genvar p = 0; p < NPLANE; p++) begin : g_s1
    rgb_t          fg_in;
    logic [AW-1:0] a_in;
    assign fg_in = pl_palmode[p] ? rgb_t'(pal_rd[p*RGB_W +: RGB_W])
                                 : from565(pl_pix[p*PIX_W +: 16]);
    assign a_in  = (pl_en[p] && pl_valid[p]) ? pl_alpha[p*AW +: AW] : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_fg[p] <= '0;
        s1_a[p]  <= '0;
      end else if (take) begin
        s1_fg[p] <= fg_in;
        s1_a[p]  <= a_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_vid <= '0;
    end else if (adv) begin
      s1_vld <= vid_valid;
      if (vid_valid) s1_vid <= vid_pix;
    end
  end

  // Layer table indexed by ID: planes first, video last and opaque
  rgb_t          lay_fg [NSLOT];
  logic [AW-1:0] lay_a  [NSLOT];

  always_comb begin
    for (int p = 0; p < NPLANE; p++) begin
      lay_fg[p] = s1_fg[p];
      lay_a[p]  = s1_a[p];
    end
    lay_fg[NPLANE] = s1_vid;
    lay_a[NPLANE]  = '1;
  end

  // Stage 2: blend chain from bottom slot to top slot
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [ID_W-1:0] sid;
    rgb_t            bg, mixed;
    assign sid = order[s*ID_W +: ID_W];
    if (s == 0) begin : g_base
      assign bg = '0;
    end else begin : g_link
      assign bg = g_slot[s-1].mixed;
    end
    ovl_blend #(.AW(AW)) u_blend (
      .fg(lay_fg[sid]), .bg(bg), .alpha(lay_a[sid]), .mix(mixed)
    );
  end

  logic sup_c;
  always_comb begin
    logic seen;
    seen  = 1'b0;
    sup_c = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      logic [ID_W-1:0] id;
      id = order[s*ID_W +: ID_W];
      if (id == VID_ID)                    seen  = 1'b1;
      else if (seen && lay_a[id] != '0)    sup_c = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_sup_n <= 1'b1;
    end else if (adv) begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_rgb   <= g_slot[NSLOT-1].mixed;
        out_sup_n <= !sup_c;
      end else begin
        out_sup_n <= 1'b1;
      end
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_sup_n)));
  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> vid_ready);
  p_no_take_in_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && s1_vld) |=> s1_vld);
  p_sup_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_sup_n);
endmodule

// File: tb/overlay_mixer_bench.sv
module overlay_mixer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        vid_valid = 0, vid_fmt = 0, out_ready = 1;
  logic [17:0] vid_data = 0;
  logic [2:0]  pl_en = 0, pl_palmode = 0, pl_valid = 3'b111;
  logic [47:0] pl_pix = 0;
  logic [11:0] pl_alpha = 0;
  logic        pal_we = 0, ord_we = 0;
  logic [7:0]  pal_waddr = 0, ord_wdata = 0;
  logic [23:0] pal_wdata = 0;
  logic        vid_ready, out_valid, out_sup_n;
  logic [23:0] out_rgb;

  always #10 clk = ~clk;

  overlay_mixer u_overlay_mixer (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_ready(vid_ready),
    .vid_fmt(vid_fmt), .vid_data(vid_data), .pl_en(pl_en), .pl_palmode(pl_palmode),
    .pl_valid(pl_valid), .pl_pix(pl_pix), .pl_alpha(pl_alpha), .pal_we(pal_we),
    .pal_waddr(pal_waddr), .pal_wdata(pal_wdata), .ord_we(ord_we), .ord_wdata(ord_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb), .out_sup_n(out_sup_n)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  logic [24:0] exp_q[$];
  int m_pal [256];
  int m_ord [4];
  int m_phase = 0, m_cb = 128, m_cr = 128;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return v < 0 ? 0 : (v > 255 ? 255 : v);
  endfunction

  // Behavioural model of one accepted beat
  task automatic model_push();
    int vid[3], fg[3][3], a[3], acc[3];
    int cb, cr, y, dcb, dcr;
    bit seen, sup;
    if (vid_fmt) begin
      y  = vid_data[15:8];
      cb = (m_phase == 0) ? int'(vid_data[7:0]) : m_cb;
      cr = (m_phase == 1) ? int'(vid_data[7:0]) : m_cr;
      dcb = cb - 128; dcr = cr - 128;
      vid[0] = clip(y + ((359*dcr) >>> 8));
      vid[1] = clip(y - ((88*dcb + 183*dcr) >>> 8));
      vid[2] = clip(y + ((454*dcb) >>> 8));
      if (m_phase == 0) m_cb = vid_data[7:0]; else m_cr = vid_data[7:0];
      m_phase = 1 - m_phase;
    end else begin
      for (int c = 0; c < 3; c++) begin
        int v6;
        v6 = (vid_data >> (12 - 6*c)) & 63;
        vid[c] = (v6 << 2) | (v6 >> 4);
      end
    end
    for (int p = 0; p < 3; p++) begin
      int px;
      px = (pl_pix >> (16*p)) & 16'hFFFF;
      if (pl_palmode[p]) begin
        int e;
        e = m_pal[px & 255];
        fg[p][0] = (e >> 16) & 255; fg[p][1] = (e >> 8) & 255; fg[p][2] = e & 255;
      end else begin
        int r5, g6, b5;
        r5 = (px >> 11) & 31; g6 = (px >> 5) & 63; b5 = px & 31;
        fg[p][0] = (r5 << 3) | (r5 >> 2);
        fg[p][1] = (g6 << 2) | (g6 >> 4);
        fg[p][2] = (b5 << 3) | (b5 >> 2);
      end
      a[p] = (pl_en[p] && pl_valid[p]) ? int'((pl_alpha >> (4*p)) & 15) : 0;
    end
    acc = '{0, 0, 0};
    seen = 0; sup = 0;
    for (int s = 0; s < 4; s++) begin
      int id;
      id = m_ord[s];
      if (id == 3) begin
        acc = vid; seen = 1;
      end else begin
        for (int c = 0; c < 3; c++) acc[c] = (a[id]*fg[id][c] + (15 - a[id])*acc[c]) / 15;
        if (seen && a[id] != 0) sup = 1;
      end
    end
    exp_q.push_back({~sup, acc[0][7:0], acc[1][7:0], acc[2][7:0]});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, cur_req, {7'd0, out_sup_n, out_rgb}, 32'hFFFFFFFF);
        else begin
          logic [24:0] e;
          e = exp_q.pop_front();
          check({out_sup_n, out_rgb} == e, cur_req, {7'd0, out_sup_n, out_rgb}, {7'd0, e});
        end
      end
      if (vid_valid && vid_ready) model_push();
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog %s actual=%0d expected=<150000", cur_req, cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send();
    vid_valid = 1;
    @(negedge clk);
    while (!vid_ready) @(negedge clk);
    @(posedge clk); #1;
    vid_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) begin @(posedge clk); #1; end
  endtask

  task automatic set_plane(input int p, input logic en, input logic pm, input logic [15:0] px, input logic [3:0] a);
    pl_en[p] = en; pl_palmode[p] = pm;
    pl_pix[16*p +: 16] = px; pl_alpha[4*p +: 4] = a;
  endtask

  task automatic pal_write(input logic [7:0] ad, input logic [23:0] d);
    pal_we = 1; pal_waddr = ad; pal_wdata = d;
    @(posedge clk); #1; pal_we = 0;
    m_pal[ad] = int'(d);
  endtask

  task automatic ord_write(input logic [7:0] w);
    int cnt[4];
    bit ok;
    ord_we = 1; ord_wdata = w;
    @(posedge clk); #1; ord_we = 0;
    cnt = '{0, 0, 0, 0};
    for (int s = 0; s < 4; s++) cnt[(w >> (2*s)) & 3]++;
    ok = 1;
    for (int i = 0; i < 4; i++) if (cnt[i] != 1) ok = 0;
    if (ok) for (int s = 0; s < 4; s++) m_ord[s] = (w >> (2*s)) & 3;
  endtask

  initial begin
    m_ord = '{3, 0, 1, 2};
    for (int i = 0; i < 256; i++) m_pal[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check(out_valid == 0, "R1", {31'd0, out_valid}, 0);
    check(out_sup_n == 1, "R1", {31'd0, out_sup_n}, 1);
    check(vid_ready == 1, "R1", {31'd0, vid_ready}, 1);
    @(posedge clk); #1;
    // R1 default order: plane 2 sits above plane 0
    set_plane(0, 1, 0, 16'hF800, 4'd15);
    set_plane(2, 1, 0, 16'h001F, 4'd15);
    vid_data = 18'h3FFFF; send(); drain();
    set_plane(0, 0, 0, 0, 0); set_plane(2, 0, 0, 0, 0);

    // R9 video only in RGB666
    cur_req = "R9";
    for (int i = 0; i < 6; i++) begin vid_data = 18'((i * 18'h0A5C3) ^ 18'h15A5A); send(); end
    drain();

    // R3 direct plane colours over video
    cur_req = "R3";
    for (int i = 0; i < 6; i++) begin
      set_plane(1, 1, 0, 16'((i * 16'h3B1D) ^ 16'h8421), 4'd15);
      vid_data = 18'h0F0F0; send();
    end
    drain();

    // R5 alpha sweep of plane 0 over video
    cur_req = "R5";
    set_plane(1, 0, 0, 0, 0);
    for (int a = 0; a < 16; a++) begin
      set_plane(0, 1, 0, 16'hFFE0, 4'(a));
      vid_data = 18'h00FC3; send();
    end
    drain();

    // R6 disabled plane and missing pixel
    cur_req = "R6";
    set_plane(0, 0, 0, 16'hFFFF, 4'd15); vid_data = 18'h12345; send();
    set_plane(0, 1, 0, 16'hFFFF, 4'd15); pl_valid = 3'b110; send();
    pl_valid = 3'b111; send();
    drain();

    // R4 colour table mode
    cur_req = "R4";
    pal_write(8'h00, 24'h102030);
    pal_write(8'h7F, 24'hFF8000);
    pal_write(8'hFF, 24'h00FFAA);
    set_plane(0, 0, 0, 0, 0);
    set_plane(1, 1, 1, 16'hAB7F, 4'd15); vid_data = 18'h0; send();
    set_plane(1, 1, 1, 16'h00FF, 4'd9);  send();
    set_plane(1, 1, 1, 16'h0000, 4'd4);  vid_data = 18'h3FFFF; send();
    drain();

    // R7 new order, then a rejected word
    cur_req = "R7";
    ord_write(8'h1B);
    set_plane(0, 1, 0, 16'hF800, 4'd8);
    set_plane(1, 1, 1, 16'h007F, 4'd6);
    set_plane(2, 1, 0, 16'h07E0, 4'd11);
    vid_data = 18'h2A2A2; send(); send();
    drain();
    ord_write(8'h00);
    send();
    ord_write(8'hE7);
    send();
    drain();

    // R8 video on top hides all planes; video in the middle
    cur_req = "R8";
    ord_write(8'hE4);
    send(); drain();
    ord_write(8'h9C);
    send(); drain();

    // R11 flag with the only active plane below video
    cur_req = "R11";
    set_plane(2, 0, 0, 0, 0);
    set_plane(1, 0, 0, 0, 0);
    send();
    set_plane(2, 1, 0, 16'h1234, 4'd1); send();
    drain();

    // R10 YCrCb stream
    cur_req = "R10";
    ord_write(8'h93);
    set_plane(0, 0, 0, 0, 0); set_plane(1, 0, 0, 0, 0); set_plane(2, 0, 0, 0, 0);
    vid_fmt = 1;
    vid_data = 18'h0_5A_F0; send();
    vid_data = 18'h0_80_10; send();
    vid_data = 18'h0_EB_30; send();
    vid_data = 18'h0_10_E0; send();
    vid_data = 18'h0_C8_80; send();
    drain();
    vid_fmt = 0;

    // R2 latency
    cur_req = "R2";
    vid_data = 18'h13579; vid_valid = 1;
    @(posedge clk); #1 vid_valid = 0;
    @(negedge clk); check(out_valid == 0, "R2", {31'd0, out_valid}, 0);
    @(negedge clk); check(out_valid == 1, "R2", {31'd0, out_valid}, 1);
    drain();
    // R2 back-pressure
    out_ready = 0;
    vid_data = 18'h0ABCD; send();
    vid_data = 18'h3C3C3; send();
    @(negedge clk);
    begin
      logic [23:0] held;
      held = out_rgb;
      for (int k = 0; k < 4; k++) begin
        check(out_valid == 1 && out_rgb == held, "R2", {8'd0, out_rgb}, {8'd0, held});
        check(vid_ready == 0, "R2", {31'd0, vid_ready}, 0);
        @(negedge clk);
      end
    end
    @(posedge clk); #1 out_ready = 1;
    drain();
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule